// File: doc/BRIEF.md
# Stop-Mode Wake and Recovery Sequencer

This block parks the device in a low-power stop state when the CPU asks for it, and later brings it back. It watches two kinds of wake source while stopped. One is a watchdog time-out, which comes with the watchdog's configured action (plain reset or system exception). The other is a bank of general-purpose input pins, and each pin has its own wake-enable bit. A pin wakes the device when it moves away from the level it had at stop entry, in either direction. The new level has to stay put for a programmable number of clock cycles, so that short glitches are rejected.

A wake starts a partial reset. The core reset line is held for a fixed number of oscillator cycles. Only the reset status bits and the oscillator enable change; everything else is left alone. The block then reads a two-byte reset vector from program memory, high byte first, through a request/valid handshake. It pulses a load strobe along with the assembled program-counter value. When the wake came from the watchdog and the watchdog is set for exception, a one-cycle exception request follows the load strobe.

Top module: `stop_wake_seq`

## Requirements
- R1: A `stop_req` in the running state sets `stopped` to 1 and `osc_en` to 0 from the next cycle. Both hold until a wake event is seen.
- R2: After a wake event, `core_rst` rises in the next cycle. It stays high for exactly HOLD_CYCLES consecutive cycles and never rises unless a wake was taken from stop.
- R3: Every recovery sets `stat_stop` to 1. `stat_wdt` is set to 1 when the watchdog caused the wake and cleared to 0 when a pin did.
- R4: After the hold, the block requests address VEC_HI_ADDR (0x0002) and then VEC_LO_ADDR (0x0003). Each request is held until `mem_rd_valid`. `pc_load` pulses for one cycle, one cycle after the second valid, and `pc_value` = {high byte, low byte}. `stopped` returns to 0 and `osc_en` to 1.
- R5: For a watchdog wake with `wdt_exc_mode`=1, `wdt_exc_req` pulses exactly once, in the cycle after `pc_load`. With `wdt_exc_mode`=0, or for a pin wake, it stays 0.
- R6: An enabled pin whose level differs from the level captured at stop entry, in either direction, wakes the block. The difference must last FILT_CYCLES consecutive cycles, and `core_rst` rises one cycle after the last of them.
- R7: A difference that lasts fewer than FILT_CYCLES cycles and then returns causes no wake.
- R8: A pin whose `gpio_wake_en` bit is 0 never causes a wake, whatever it does.
- R9: Watchdog time-outs and pin changes while not in stop are ignored: `core_rst` stays 0 and the status bits keep their values.
- R10: When a watchdog time-out and a pin wake occur in the same cycle, the watchdog wins and `stat_wdt` becomes 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low power-on reset |
| stop_req | input | 1 | CPU executed the stop instruction |
| wdt_timeout | input | 1 | Watchdog time-out event |
| wdt_exc_mode | input | 1 | 1: watchdog set for system exception, 0: for reset |
| gpio_in | input | NUM_PINS | Pin levels |
| gpio_wake_en | input | NUM_PINS | Per-pin wake enable |
| stopped | output | 1 | Device is in stop |
| osc_en | output | 1 | Oscillator enable (low in stop) |
| core_rst | output | 1 | Core reset hold during recovery |
| stat_stop | output | 1 | Status: last reset was a stop recovery |
| stat_wdt | output | 1 | Status: watchdog caused the recovery |
| mem_rd_req | output | 1 | Program memory read request |
| mem_rd_addr | output | ADDR_W | Program memory read address |
| mem_rd_valid | input | 1 | Read data valid |
| mem_rd_data | input | DATA_W | Read data byte |
| pc_load | output | 1 | One-cycle program counter load strobe |
| pc_value | output | 2*DATA_W | Reset vector for the program counter |
| wdt_exc_req | output | 1 | Deferred watchdog exception request |

## Verification
The bench builds the block with six pins, a three-cycle filter and the default 66-cycle hold. With the short filter, glitches one cycle shorter than the threshold and the exact-length boundary both fit into a few cycles. The pin count is small enough that disabled pins and random enable masks are hit often. The full hold length is kept, so the reset width is checked at its real value. Random memory latency of zero to three cycles exercises the request-hold behaviour of both vector reads.

// File: rtl/swk_pkg.sv
package swk_pkg;

  typedef enum logic [2:0] {
    SQ_RUN   = 3'd0,
    SQ_STOP  = 3'd1,
    SQ_HOLD  = 3'd2,
    SQ_FETCH = 3'd3,
    SQ_EXC   = 3'd4
  } sq_state_t;

  typedef enum logic [1:0] {
    FP_IDLE = 2'd0,
    FP_HI   = 2'd1,
    FP_LO   = 2'd2
  } fetch_phase_t;

  // Counter has reached the last cycle of a window of 'len' cycles.
  function automatic logic at_last(input logic [31:0] cnt, input int unsigned len);
    return cnt == 32'(len - 1);
  endfunction

  // A pin differs from its reference level.
  function automatic logic level_moved(input logic now_lvl, input logic ref_lvl);
    return now_lvl ^ ref_lvl;
  endfunction

endpackage

// File: rtl/swk_pin_filter.sv
module swk_pin_filter #(
  parameter int unsigned FILT_CYCLES = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic active,
  input  logic enable,
  input  logic pin,
  output logic hit
);
  import swk_pkg::*;

  localparam int unsigned CW = $clog2(FILT_CYCLES + 1);

  logic          ref_q;
  logic [CW-1:0] run_q;
  logic          moved;
  logic          counting;

  assign moved    = level_moved(pin, ref_q);
  assign counting = active && enable && moved && !arm;
  assign hit      = counting && at_last(32'(run_q), FILT_CYCLES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= 1'b0;
      run_q <= '0;
    end else begin
      if (arm) ref_q <= pin;
      if (!counting) run_q <= '0;
      else if (!hit) run_q <= run_q + 1'b1;
    end
  end

endmodule

// File: rtl/swk_hold_timer.sv
module swk_hold_timer #(
  parameter int unsigned HOLD_CYCLES = 66
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic last
);
  import swk_pkg::*;

  localparam int unsigned HW = $clog2(HOLD_CYCLES + 1);

  logic [HW-1:0] cnt_q;
  logic          busy_q;

  assign busy = busy_q;
  assign last = busy_q && at_last(32'(cnt_q), HOLD_CYCLES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (last) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/swk_vec_fetch.sv
module swk_vec_fetch #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned DATA_W  = 8,
  parameter logic [ADDR_W-1:0] HI_ADDR = 16'h0002,
  parameter logic [ADDR_W-1:0] LO_ADDR = 16'h0003
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  output logic                  rd_req,
  output logic [ADDR_W-1:0]     rd_addr,
  input  logic                  rd_valid,
  input  logic [DATA_W-1:0]     rd_data,
  output logic                  done,
  output logic [2*DATA_W-1:0]   vec
);
  import swk_pkg::*;

  fetch_phase_t      phase_q;
  logic [DATA_W-1:0] hi_q;
  logic [DATA_W-1:0] lo_q;
  logic              done_q;

  assign rd_req  = (phase_q != FP_IDLE);
  assign rd_addr = (phase_q == FP_LO) ? LO_ADDR : HI_ADDR;
  assign done    = done_q;
  assign vec     = {hi_q, lo_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= FP_IDLE;
      hi_q    <= '0;
      lo_q    <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        FP_IDLE: if (start) phase_q <= FP_HI;
        FP_HI: if (rd_valid) begin
          hi_q    <= rd_data;
          phase_q <= FP_LO;
        end
        FP_LO: if (rd_valid) begin
          lo_q    <= rd_data;
          done_q  <= 1'b1;
          phase_q <= FP_IDLE;
        end
        default: phase_q <= FP_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/stop_wake_seq.sv
module stop_wake_seq #(
  parameter int unsigned NUM_PINS    = 8,
  parameter int unsigned FILT_CYCLES = 3,
  parameter int unsigned HOLD_CYCLES = 66,
  parameter int unsigned ADDR_W      = 16,
  parameter int unsigned DATA_W      = 8,
  parameter logic [ADDR_W-1:0] VEC_HI_ADDR = 16'h0002,
  parameter logic [ADDR_W-1:0] VEC_LO_ADDR = 16'h0003
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  stop_req,
  input  logic                  wdt_timeout,
  input  logic                  wdt_exc_mode,
  input  logic [NUM_PINS-1:0]   gpio_in,
  input  logic [NUM_PINS-1:0]   gpio_wake_en,
  output logic                  stopped,
  output logic                  osc_en,
  output logic                  core_rst,
  output logic                  stat_stop,
  output logic                  stat_wdt,
  output logic                  mem_rd_req,
  output logic [ADDR_W-1:0]     mem_rd_addr,
  input  logic                  mem_rd_valid,
  input  logic [DATA_W-1:0]     mem_rd_data,
  output logic                  pc_load,
  output logic [2*DATA_W-1:0]   pc_value,
  output logic                  wdt_exc_req
);
  import swk_pkg::*;

  sq_state_t           state_q;
  logic [NUM_PINS-1:0] pin_hit;
  logic                stop_enter;
  logic                in_stop;
  logic                wdt_evt;
  logic                gpio_evt;
  logic                wake_evt;
  logic                hold_busy;
  logic                hold_last;
  logic                fetch_done;
  logic                exc_pend_q;
  logic                stat_stop_q;
  logic                stat_wdt_q;

  assign in_stop    = (state_q == SQ_STOP);
  assign stop_enter = (state_q == SQ_RUN) && stop_req;
  assign wdt_evt    = in_stop && wdt_timeout;
  assign gpio_evt   = in_stop && (|pin_hit);
  assign wake_evt   = wdt_evt || gpio_evt;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    swk_pin_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .arm    (stop_enter),
      .active (in_stop),
      .enable (gpio_wake_en[p]),
      .pin    (gpio_in[p]),
      .hit    (pin_hit[p])
    );
  end

  swk_hold_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .start (wake_evt),
    .busy  (hold_busy),
    .last  (hold_last)
  );

  swk_vec_fetch #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .HI_ADDR (VEC_HI_ADDR),
    .LO_ADDR (VEC_LO_ADDR)
  ) u_fetch (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (hold_last),
    .rd_req   (mem_rd_req),
    .rd_addr  (mem_rd_addr),
    .rd_valid (mem_rd_valid),
    .rd_data  (mem_rd_data),
    .done     (fetch_done),
    .vec      (pc_value)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= SQ_RUN;
      exc_pend_q  <= 1'b0;
      stat_stop_q <= 1'b0;
      stat_wdt_q  <= 1'b0;
    end else begin
      unique case (state_q)
        SQ_RUN:  if (stop_req) state_q <= SQ_STOP;
        SQ_STOP: if (wake_evt) begin
          state_q     <= SQ_HOLD;
          stat_stop_q <= 1'b1;
          stat_wdt_q  <= wdt_evt;
          exc_pend_q  <= wdt_evt && wdt_exc_mode;
        end
        SQ_HOLD:  if (hold_last) state_q <= SQ_FETCH;
        SQ_FETCH: if (fetch_done) state_q <= exc_pend_q ? SQ_EXC : SQ_RUN;
        SQ_EXC: begin
          exc_pend_q <= 1'b0;
          state_q    <= SQ_RUN;
        end
        default: state_q <= SQ_RUN;
      endcase
    end
  end

  assign stopped     = in_stop;
  assign osc_en      = !in_stop;
  assign core_rst    = hold_busy;
  assign stat_stop   = stat_stop_q;
  assign stat_wdt    = stat_wdt_q;
  assign pc_load     = fetch_done;
  assign wdt_exc_req = (state_q == SQ_EXC);

endmodule

// File: rtl/swk_checker.sv
module swk_checker #(
  parameter int unsigned HOLD_CYCLES = 66,
  parameter int unsigned ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] HI_ADDR = 16'h0002,
  parameter logic [ADDR_W-1:0] LO_ADDR = 16'h0003
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stopped,
  input logic              wake_evt,
  input logic              core_rst,
  input logic              stat_stop,
  input logic              mem_rd_req,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic              pc_load,
  input logic              wdt_exc_req
);

  logic [31:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_len <= '0;
    else if (core_rst) run_len <= run_len + 1;
    else run_len <= '0;
  end

  // R1
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped && !wake_evt) |=> stopped);

  // R2
  rst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_rst) |-> (run_len == 32'(HOLD_CYCLES)));

  // R2
  rst_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |-> (run_len < 32'(HOLD_CYCLES)));

  // R2
  rst_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_rst) |-> $past(stopped));

  // R4
  fetch_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> (mem_rd_addr == HI_ADDR || mem_rd_addr == LO_ADDR));

  // R4
  fetch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst |-> !mem_rd_req);

  // R3
  load_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> stat_stop);

  // R5
  exc_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_exc_req |-> $past(pc_load));

endmodule

bind stop_wake_seq swk_checker #(
  .HOLD_CYCLES (HOLD_CYCLES),
  .ADDR_W      (ADDR_W),
  .HI_ADDR     (VEC_HI_ADDR),
  .LO_ADDR     (VEC_LO_ADDR)
) u_swk_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .stopped     (stopped),
  .wake_evt    (wake_evt),
  .core_rst    (core_rst),
  .stat_stop   (stat_stop),
  .mem_rd_req  (mem_rd_req),
  .mem_rd_addr (mem_rd_addr),
  .pc_load     (pc_load),
  .wdt_exc_req (wdt_exc_req)
);

// File: tb/tb_stop_wake_seq.sv
module tb_stop_wake_seq;

  localparam int unsigned NP   = 6;
  localparam int unsigned FILT = 3;
  localparam int unsigned HOLD = 66;
  localparam int unsigned AW   = 16;
  localparam int unsigned DW   = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            stop_req = 1'b0;
  logic            wdt_timeout = 1'b0;
  logic            wdt_exc_mode = 1'b0;
  logic [NP-1:0]   gpio_in = '0;
  logic [NP-1:0]   gpio_wake_en = '0;
  logic            stopped, osc_en, core_rst, stat_stop, stat_wdt;
  logic            mem_rd_req;
  logic [AW-1:0]   mem_rd_addr;
  logic            mem_rd_valid = 1'b0;
  logic [DW-1:0]   mem_rd_data = '0;
  logic            pc_load;
  logic [2*DW-1:0] pc_value;
  logic            wdt_exc_req;

  stop_wake_seq #(
    .NUM_PINS(NP), .FILT_CYCLES(FILT), .HOLD_CYCLES(HOLD),
    .ADDR_W(AW), .DATA_W(DW)
  ) dut (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .wdt_timeout(wdt_timeout),
    .wdt_exc_mode(wdt_exc_mode), .gpio_in(gpio_in), .gpio_wake_en(gpio_wake_en),
    .stopped(stopped), .osc_en(osc_en), .core_rst(core_rst),
    .stat_stop(stat_stop), .stat_wdt(stat_wdt), .mem_rd_req(mem_rd_req),
    .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
    .mem_rd_data(mem_rd_data), .pc_load(pc_load), .pc_value(pc_value),
    .wdt_exc_req(wdt_exc_req)
  );

  always #4 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done_flag = 0;

  // memory model and monitor state
  logic [DW-1:0] vec_hi = 8'h12, vec_lo = 8'h34;
  int lat = 0, wait_cnt = 0;
  int n_addr = 0;
  logic [AW-1:0] addr_log [4];
  int cyc = 0, rst_len = 0, load_cyc = 0, exc_cyc = 0, exc_n = 0;
  bit load_seen = 0;

  function automatic logic [2*DW-1:0] expect_pc(input logic [DW-1:0] h, input logic [DW-1:0] l);
    return (2*DW)'(h) * 256 + (2*DW)'(l);
  endfunction

  function automatic logic [DW-1:0] mem_byte(input logic [AW-1:0] a);
    if (a == 16'h0002) return vec_hi;
    if (a == 16'h0003) return vec_lo;
    return 8'hEE;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mem_rd_valid) mem_rd_valid <= 1'b0;
    else if (mem_rd_req) begin
      if (wait_cnt >= lat) begin
        mem_rd_valid <= 1'b1;
        mem_rd_data  <= mem_byte(mem_rd_addr);
        if (n_addr < 4) addr_log[n_addr] <= mem_rd_addr;
        n_addr   <= n_addr + 1;
        wait_cnt <= 0;
      end else wait_cnt <= wait_cnt + 1;
    end
  end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (core_rst) rst_len <= rst_len + 1;
    if (pc_load) begin load_seen <= 1'b1; load_cyc <= cyc; end
    if (wdt_exc_req) begin exc_n <= exc_n + 1; exc_cyc <= cyc; end
  end

  task automatic enter_stop();
    @(negedge clk) stop_req = 1'b1;
    @(negedge clk) stop_req = 1'b0;
    chk(stopped == 1'b1, "R1", "stopped after stop_req", stopped, 1);
    chk(osc_en == 1'b0, "R1", "osc_en in stop", osc_en, 0);
    rst_len = 0; load_seen = 0; exc_n = 0; n_addr = 0;
  endtask

  task automatic finish_recovery(input bit exp_wdt, input bit exp_exc);
    int guard = 0;
    while (!load_seen && guard < 600) begin @(negedge clk); guard++; end
    chk(load_seen, "R4", "pc_load seen", load_seen, 1);
    chk(rst_len == HOLD, "R2", "core_rst width", rst_len, HOLD);
    chk(n_addr == 2 && addr_log[0] == 16'h0002 && addr_log[1] == 16'h0003,
        "R4", "fetch order", {addr_log[0], addr_log[1]}, 32'h00020003);
    chk(pc_value == expect_pc(vec_hi, vec_lo), "R4", "pc_value",
        pc_value, expect_pc(vec_hi, vec_lo));
    chk(stat_stop == 1'b1, "R3", "stat_stop", stat_stop, 1);
    chk(stat_wdt == exp_wdt, "R3", "stat_wdt", stat_wdt, exp_wdt);
    repeat (3) @(negedge clk);
    chk(stopped == 1'b0 && osc_en == 1'b1, "R4", "running after load",
        {stopped, osc_en}, 2'b01);
    chk(exc_n == int'(exp_exc), "R5", "exception count", exc_n, exp_exc);
    if (exp_exc) chk(exc_cyc == load_cyc + 1, "R5", "exception timing",
                     exc_cyc - load_cyc, 1);
  endtask

  task automatic wake_by_wdt(input bit exc);
    wdt_exc_mode = exc;
    @(negedge clk) wdt_timeout = 1'b1;
    @(negedge clk) wdt_timeout = 1'b0;
    chk(core_rst == 1'b1, "R2", "core_rst after wdt wake", core_rst, 1);
  endtask

  task automatic wake_by_pin(input int p);
    @(negedge clk) gpio_in[p] = ~gpio_in[p];
    for (int k = 1; k <= int'(FILT); k++) begin
      @(negedge clk);
      if (k == int'(FILT) - 1)
        chk(core_rst == 1'b0, "R6", "no wake before filter", core_rst, 0);
      if (k == int'(FILT))
        chk(core_rst == 1'b1, "R6", "wake at filter length", core_rst, 1);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    chk(!stopped && osc_en && !core_rst && !stat_stop && !stat_wdt && !mem_rd_req,
        "R1", "reset state", {stopped, osc_en, core_rst, stat_stop, stat_wdt}, 5'b01000);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);

    // R9: events while running are ignored
    gpio_wake_en = '1;
    @(negedge clk) begin wdt_timeout = 1'b1; gpio_in = ~gpio_in; end
    @(negedge clk) wdt_timeout = 1'b0;
    repeat (6) @(negedge clk);
    chk(!core_rst && !stat_stop && !stat_wdt && !stopped, "R9", "run-time events ignored",
        {core_rst, stat_stop, stat_wdt}, 0);

    // directed: watchdog wake, reset mode
    vec_hi = 8'hA5; vec_lo = 8'h0F; lat = 0;
    enter_stop();
    wake_by_wdt(1'b0);
    finish_recovery(1'b1, 1'b0);

    // R9 again with a set status
    @(negedge clk) begin wdt_timeout = 1'b1; gpio_in[0] = ~gpio_in[0]; end
    @(negedge clk) wdt_timeout = 1'b0;
    repeat (6) @(negedge clk);
    chk(!core_rst && stat_wdt && stat_stop, "R9", "status kept while running",
        {core_rst, stat_stop, stat_wdt}, 3'b011);

    // directed: pin wake rising and falling, exception mode on a pin wake
    gpio_in = 6'b000000; gpio_wake_en = 6'b000100; wdt_exc_mode = 1'b1;
    vec_hi = 8'h00; vec_lo = 8'hFF; lat = 2;
    enter_stop();
    wake_by_pin(2);
    finish_recovery(1'b0, 1'b0);
    enter_stop();
    wake_by_pin(2);
    finish_recovery(1'b0, 1'b0);

    // R7: short glitch rejected, R8: disabled pin ignored
    gpio_wake_en = 6'b000010;
    enter_stop();
    @(negedge clk) gpio_in[1] = ~gpio_in[1];
    repeat (FILT - 1) @(negedge clk);
    gpio_in[1] = ~gpio_in[1];
    repeat (8) @(negedge clk);
    chk(stopped && !core_rst, "R7", "short glitch ignored", {stopped, core_rst}, 2'b10);
    @(negedge clk) gpio_in[4] = ~gpio_in[4];
    repeat (10) @(negedge clk);
    chk(stopped && !core_rst, "R8", "disabled pin ignored", {stopped, core_rst}, 2'b10);
    vec_hi = 8'h7E; vec_lo = 8'h81; lat = 1;
    wake_by_wdt(1'b1);
    finish_recovery(1'b1, 1'b1);

    // R10: watchdog and pin in the same cycle
    gpio_wake_en = 6'b100000;
    enter_stop();
    @(negedge clk) gpio_in[5] = ~gpio_in[5];
    repeat (FILT - 1) @(negedge clk);
    wdt_exc_mode = 1'b0; wdt_timeout = 1'b1;
    @(negedge clk) wdt_timeout = 1'b0;
    chk(core_rst == 1'b1, "R10", "joint wake", core_rst, 1);
    finish_recovery(1'b1, 1'b0);
    chk(stat_wdt == 1'b1, "R10", "watchdog wins", stat_wdt, 1);

    // random recoveries
    for (int it = 0; it < 24; it++) begin
      int cause = int'($urandom % 3);
      int p = int'($urandom % NP);
      @(negedge clk) gpio_in = NP'($urandom);
      gpio_wake_en = NP'($urandom) | (NP'(1) << p);
      vec_hi = DW'($urandom); vec_lo = DW'($urandom); lat = int'($urandom % 4);
      enter_stop();
      if (cause == 2) begin
        wdt_exc_mode = 1'($urandom);
        wake_by_pin(p);
        finish_recovery(1'b0, 1'b0);
      end else begin
        wake_by_wdt(cause == 1);
        finish_recovery(1'b1, cause == 1);
      end
    end

    done_flag = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule